// File: doc/BRIEF.md
# Addressed Serial Quad-DAC Loader

This block is the digital front end of a four-channel 14-bit converter. It takes serial words of 16 bits on a single data line. A bit clock and an active-low frame strobe qualify the data line. All three lines are oversampled in the system clock domain. Writes arrive as pairs of frames. The first frame of a pair is an address frame. It carries a five-bit package address, a channel number and an address-enable flag. The second frame is a data frame. It holds a 14-bit code behind two leading zeros. Up to 32 devices can share one bus, because each device compares the package address against its own five strap inputs.

Each channel has two storage stages. An input register receives the accepted data code. An output latch drives the converter. While the active-low load input is held low, the output latches follow the input registers. A short low pulse therefore updates all channels together. Holding the load input low lets each accepted write reach its output straight away. The active-low clear input acts at once, without waiting for a clock edge. It forces every output latch to the clear code and leaves the input registers alone. A frame that the strobe ends early is thrown away and raises a frame-error flag.

The serial data path has no back-pressure, so every word must be taken as it arrives. The load, clear and strap pins are plain control levels.

Top module: `quad_dac_loader`

## Requirements
- R1: After reset, every output latch holds the clear code (default 14'h2000) and frame_err is 0.
- R2: A frame is 16 bits, sent MSB first. A bit is taken on each falling edge of sclk while fsync_n is low. Frames alternate between address and data, starting with an address frame. Address frame fields: bits [15:11] are the package address, bits [10:9] the channel, and bit 8 the address-enable flag. Data frame fields: bits [15:14] are the lead bits and bits [13:0] the code. Channel i is carried on dac_code[14*i+13:14*i].
- R3: When the address-enable flag is 1 and the package address differs from strap_addr, the data frame that follows changes no input register.
- R4: When the address-enable flag is 0, the data frame that follows is accepted whatever the value of strap_addr.
- R5: A data frame whose lead bits [15:14] are not 00 changes no input register.
- R6: While load_n is high, the output latches keep their values even when input registers are written.
- R7: A low pulse on load_n copies all four input registers into their output latches.
- R8: While load_n stays low, each accepted data frame appears on its channel's output without any further pulse.
- R9: clr_n low forces all output latches to the clear code at once, without waiting for a clock edge. The latches stay at the clear code while clr_n is low, even if load_n is low.
- R10: Clearing leaves the input registers unchanged. A load after clr_n is released restores the codes written before the clear.
- R11: If fsync_n rises after 1 to 15 bits of a frame, the frame is discarded and frame_err becomes 1. The next frame is taken as an address frame. The next complete frame of 16 bits clears frame_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bit clock, idles high; data taken on its falling edge |
| fsync_n | input | 1 | Active-low frame strobe |
| sdin | input | 1 | Serial data, MSB first |
| strap_addr | input | 5 | Package address straps of this device |
| load_n | input | 1 | Active-low load: output latches follow input registers while low |
| clr_n | input | 1 | Asynchronous active-low clear of the output latches |
| dac_code | output | 56 | Four 14-bit output latch codes, channel 0 in the low bits |
| frame_err | output | 1 | Set by a frame ended early, cleared by the next complete frame |

## Verification
Some internal faults do not show until a load or a later frame. A wrong channel decode or a wrong address decision is hidden while load_n is high. It appears on dac_code only after the next load pulse, so every sweep step ends with a load and a full comparison of all four channels. A frame counter that fails to reset after a short frame shifts the address and data roles of later frames. That fault is caught one write pair later, as a missing or misplaced code. A fault in the asynchronous clear shows one nanosecond after clr_n falls, before any clock edge.

// File: rtl/qdl_pkg.sv
package qdl_pkg;
  localparam int unsigned DEF_FRAME_W = 16;
  localparam int unsigned DEF_DATA_W  = 14;
  localparam int unsigned DEF_ADDR_W  = 5;
  localparam int unsigned DEF_NUM_CH  = 4;

  // which kind of frame the decoder expects next
  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/qdl_sync.sv
module qdl_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qdl_shifter.sv
module qdl_shifter #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               fsync_s,
  input  logic               sdin_s,
  output logic               frame_done,
  output logic               short_err,
  output logic [FRAME_W-1:0] word
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               sclk_d;
  logic               fsync_d;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-2:0] sh;
  logic               bit_fall;
  logic               fs_rise;

  assign bit_fall = sclk_d & ~sclk_s;
  assign fs_rise  = ~fsync_d & fsync_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d     <= 1'b1;
      fsync_d    <= 1'b1;
      cnt        <= '0;
      sh         <= '0;
      word       <= '0;
      frame_done <= 1'b0;
      short_err  <= 1'b0;
    end else begin
      sclk_d     <= sclk_s;
      fsync_d    <= fsync_s;
      frame_done <= 1'b0;
      short_err  <= 1'b0;
      if (!fsync_s && bit_fall) begin
        sh <= {sh[FRAME_W-3:0], sdin_s};
        if (cnt == LAST) begin
          word       <= {sh, sdin_s};
          frame_done <= 1'b1;
          cnt        <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (fs_rise) begin
        if (cnt != '0) short_err <= 1'b1;
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/qdl_decoder.sv
module qdl_decoder
  import qdl_pkg::*;
#(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned DATA_W  = 14,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned NUM_CH  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_done,
  input  logic                      short_err,
  input  logic [FRAME_W-1:0]        word,
  input  logic [ADDR_W-1:0]         strap_addr,
  output logic                      wr_en,
  output logic [$clog2(NUM_CH)-1:0] wr_ch,
  output logic [DATA_W-1:0]         wr_data,
  output logic                      frame_err
);
  localparam int unsigned CH_W    = $clog2(NUM_CH);
  localparam int unsigned ADDR_HI = FRAME_W - 1;
  localparam int unsigned ADDR_LO = FRAME_W - ADDR_W;
  localparam int unsigned CH_HI   = ADDR_LO - 1;
  localparam int unsigned CH_LO   = ADDR_LO - CH_W;
  localparam int unsigned EN_BIT  = CH_LO - 1;
  localparam int unsigned LEAD_W  = FRAME_W - DATA_W;

  phase_e            phase;
  logic              selected;
  logic [CH_W-1:0]   ch_q;
  logic              hit;
  logic              lead_zero;

  assign hit       = !word[EN_BIT] || (word[ADDR_HI:ADDR_LO] == strap_addr);
  assign lead_zero = (word[FRAME_W-1 -: LEAD_W] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_ADDR;
      selected  <= 1'b0;
      ch_q      <= '0;
      wr_en     <= 1'b0;
      wr_ch     <= '0;
      wr_data   <= '0;
      frame_err <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (short_err) begin
        phase     <= PH_ADDR;
        frame_err <= 1'b1;
      end else if (frame_done) begin
        frame_err <= 1'b0;
        if (phase == PH_ADDR) begin
          phase    <= PH_DATA;
          selected <= hit;
          ch_q     <= word[CH_HI:CH_LO];
        end else begin
          phase <= PH_ADDR;
          if (selected && lead_zero) begin
            wr_en   <= 1'b1;
            wr_ch   <= ch_q;
            wr_data <= word[DATA_W-1:0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/qdl_latch_bank.sv
module qdl_latch_bank #(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned NUM_CH = 4,
  parameter logic [DATA_W-1:0] CLEAR_CODE = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_n,
  input  logic                       load_act,
  input  logic                       wr_en,
  input  logic [$clog2(NUM_CH)-1:0]  wr_ch,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_CH*DATA_W-1:0]   in_flat,
  output logic [NUM_CH*DATA_W-1:0]   out_flat
);
  localparam int unsigned CH_W = $clog2(NUM_CH);

  logic latch_rst_n;
  assign latch_rst_n = rst_n & clr_n;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [DATA_W-1:0] in_q;
    logic [DATA_W-1:0] out_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                in_q <= CLEAR_CODE;
      else if (wr_en && wr_ch == CH_W'(i))       in_q <= wr_data;
    end

    always_ff @(posedge clk or negedge latch_rst_n) begin
      if (!latch_rst_n)  out_q <= CLEAR_CODE;
      else if (load_act) out_q <= in_q;
    end

    assign in_flat[i*DATA_W +: DATA_W]  = in_q;
    assign out_flat[i*DATA_W +: DATA_W] = out_q;
  end
endmodule

// File: rtl/quad_dac_loader.sv
module quad_dac_loader
  import qdl_pkg::*;
#(
  parameter int unsigned FRAME_W     = DEF_FRAME_W,
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] CLEAR_CODE = 14'h2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk,
  input  logic                     fsync_n,
  input  logic                     sdin,
  input  logic [ADDR_W-1:0]        strap_addr,
  input  logic                     load_n,
  input  logic                     clr_n,
  output logic [NUM_CH*DATA_W-1:0] dac_code,
  output logic                     frame_err
);
  localparam int unsigned CH_W = $clog2(NUM_CH);

  logic [3:0]          raw_in;
  logic [3:0]          syn;
  logic                load_act;
  logic                frame_done;
  logic                short_err;
  logic [FRAME_W-1:0]  word;
  logic                wr_en;
  logic [CH_W-1:0]     wr_ch;
  logic [DATA_W-1:0]   wr_data;
  logic [NUM_CH*DATA_W-1:0] in_flat;

  // order: load_n, fsync_n, sdin, sclk
  assign raw_in = {load_n, fsync_n, sdin, sclk};

  qdl_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1101)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  assign load_act = ~syn[3];

  qdl_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(syn[0]), .fsync_s(syn[2]), .sdin_s(syn[1]),
    .frame_done(frame_done), .short_err(short_err), .word(word)
  );

  qdl_decoder #(
    .FRAME_W(FRAME_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH)
  ) u_dec (
    .clk(clk), .rst_n(rst_n),
    .frame_done(frame_done), .short_err(short_err), .word(word),
    .strap_addr(strap_addr),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data), .frame_err(frame_err)
  );

  qdl_latch_bank #(
    .DATA_W(DATA_W), .NUM_CH(NUM_CH), .CLEAR_CODE(CLEAR_CODE)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_act(load_act),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .in_flat(in_flat), .out_flat(dac_code)
  );
endmodule

// File: rtl/qdl_checker.sv
module qdl_checker #(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned NUM_CH = 4,
  parameter logic [DATA_W-1:0] CLEAR_CODE = '0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clr_n,
  input logic                     load_act,
  input logic                     frame_done,
  input logic                     short_err,
  input logic                     wr_en,
  input logic                     frame_err,
  input logic [NUM_CH*DATA_W-1:0] in_flat,
  input logic [NUM_CH*DATA_W-1:0] dac_code
);
  // R9: clear holds every latch at the clear code
  a_r9_clear_level: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> dac_code == {NUM_CH{CLEAR_CODE}});

  // R6: without load, the output latches do not move
  a_r6_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !load_act |=> $stable(dac_code));

  // R8: with load active, outputs track the input registers one cycle later
  a_r8_follow_inputs: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    load_act |=> dac_code == $past(in_flat));

  // R11: the error flag only rises after a short frame
  a_r11_err_from_short: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> $past(short_err));

  // R2: a register write follows directly on a completed frame
  a_r2_write_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(frame_done));
endmodule

bind quad_dac_loader qdl_checker #(
  .DATA_W(DATA_W), .NUM_CH(NUM_CH), .CLEAR_CODE(CLEAR_CODE)
) u_qdl_checker (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_act(load_act),
  .frame_done(frame_done), .short_err(short_err), .wr_en(wr_en),
  .frame_err(frame_err), .in_flat(in_flat), .dac_code(dac_code)
);

// File: tb/quad_dac_loader_test.sv
module quad_dac_loader_test;
  localparam int HALF = 4;
  localparam logic [13:0] CLR_CODE = 14'h2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1;
  logic        fsync_n = 1'b1;
  logic        sdin = 1'b0;
  logic [4:0]  strap_addr = 5'd0;
  logic        load_n = 1'b1;
  logic        clr_n = 1'b1;
  logic [55:0] dac_code;
  logic        frame_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [13:0] exp_in  [4];
  logic [13:0] exp_out [4];
  bit transp = 1'b0;

  always #2 clk = ~clk;

  quad_dac_loader uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync_n(fsync_n), .sdin(sdin),
    .strap_addr(strap_addr), .load_n(load_n), .clr_n(clr_n),
    .dac_code(dac_code), .frame_err(frame_err)
  );

  function automatic logic [55:0] exp_vec();
    return {exp_out[3], exp_out[2], exp_out[1], exp_out[0]};
  endfunction

  task automatic check_outs(input string req);
    checks++;
    if (dac_code !== exp_vec()) begin
      failures++;
      $display("FAIL %s dac_code actual=%h expected=%h", req, dac_code, exp_vec());
    end
  endtask

  task automatic check_err(input string req, input logic e);
    checks++;
    if (frame_err !== e) begin
      failures++;
      $display("FAIL %s frame_err actual=%b expected=%b", req, frame_err, e);
    end
  endtask

  task automatic shift_bits(input logic [15:0] w, input int n);
    fsync_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdin = w[15-i];
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    fsync_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_pair(input logic [4:0] a, input logic en, input int ch,
                           input logic [1:0] lead, input logic [13:0] d);
    shift_bits({a, 2'(ch), en, 8'h00}, 16);
    shift_bits({lead, d}, 16);
    if ((!en || a == strap_addr) && lead == 2'b00) begin
      exp_in[ch] = d;
      if (transp) exp_out[ch] = d;
    end
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    repeat (4) @(negedge clk);
    load_n = 1'b1;
    repeat (6) @(negedge clk);
    for (int c = 0; c < 4; c++) exp_out[c] = exp_in[c];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin exp_in[c] = CLR_CODE; exp_out[c] = CLR_CODE; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check_outs("R1");
    check_err("R1", 1'b0);

    // R2 R3 R4 R6 R7: sweep all package addresses with and without enable
    for (int s = 0; s < 2; s++) begin
      strap_addr = (s == 0) ? 5'h00 : 5'h15;
      for (int a = 0; a < 32; a++) begin
        for (int en = 0; en < 2; en++) begin
          send_pair(5'(a), 1'(en), (a + en) % 4, 2'b00,
                    14'((a * 531 + en * 77 + s * 4099) & 16'h3fff));
          check_outs("R6");
          pulse_load();
          check_outs(en == 1 ? "R3" : "R4");
        end
      end
    end

    // R5: nonzero lead bits are rejected
    strap_addr = 5'h0a;
    for (int ld = 1; ld < 4; ld++) begin
      for (int ch = 0; ch < 4; ch++) begin
        send_pair(5'h0a, 1'b1, ch, 2'(ld), 14'(ld * 1000 + ch * 7));
        pulse_load();
        check_outs("R5");
      end
    end

    // R8: transparent mode with load held low
    load_n = 1'b0;
    transp = 1'b1;
    repeat (6) @(negedge clk);
    for (int ch = 0; ch < 4; ch++) begin
      send_pair(5'h0a, 1'b1, ch, 2'b00, 14'(16'h3fff - ch * 4421));
      check_outs("R8");
    end
    transp = 1'b0;
    load_n = 1'b1;
    repeat (6) @(negedge clk);

    // R9 / R10: asynchronous clear
    send_pair(5'h0a, 1'b1, 2, 2'b00, 14'h0123);
    @(negedge clk);
    clr_n = 1'b0;
    #1;
    for (int c = 0; c < 4; c++) exp_out[c] = CLR_CODE;
    check_outs("R9");
    load_n = 1'b0;
    repeat (6) @(negedge clk);
    check_outs("R9");
    load_n = 1'b1;
    repeat (4) @(negedge clk);
    clr_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outs("R9");
    pulse_load();
    check_outs("R10");

    // R11: short data frame, then short address frame
    send_pair(5'h0a, 1'b1, 1, 2'b00, 14'h1555);
    pulse_load();
    shift_bits({5'h0a, 2'd3, 1'b1, 8'h00}, 16);
    shift_bits(16'h0abc, 7);
    check_err("R11", 1'b1);
    pulse_load();
    check_outs("R11");
    send_pair(5'h0a, 1'b1, 0, 2'b00, 14'h2aaa);
    check_err("R11", 1'b0);
    pulse_load();
    check_outs("R11");
    shift_bits(16'hffff, 5);
    check_err("R11", 1'b1);
    send_pair(5'h0a, 1'b1, 3, 2'b00, 14'h0f0f);
    pulse_load();
    check_outs("R11");
    check_err("R11", 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule